// File: doc/BRIEF.md
# Machine Check and Checkstop Controller

This block is the exception-entry logic for machine check events in a 32-bit RISC core. Four cause strobes report hardware faults: the machine check pin, a transfer error acknowledge, a data parity error and an address parity error. While machine checks are enabled in the machine state register (MSR), a cause makes the block take a vectored exception. It saves the resume address and a status word in two save/restore registers (SRR0, SRR1), computes the handler's MSR and redirects fetch to the handler.

While machine checks are disabled, a cause sends the core into a terminal checkstop. The same happens on an external checkstop input or a transfer protocol error. In checkstop the block raises its checkstop output and stops changing any captured state, and only reset ends the condition. A return-from-interrupt strobe restores the MSR from SRR1 and sends fetch back to SRR0.

Bits are named with big-endian numbering (bit 0 is the MSB of the 32-bit word), so MSR bit n sits at vector index 31-n. The MSR bits used are ILE=15, EE=16, PR=17, FP=18, ME=19, IP=25, LE=31. All outputs are registered and change on the clock edge that samples the causing input.

Top module: `mchk_ctrl`

## Requirements
- R1: An accepted machine check sets redirectValid one cycle later, with redirectAddr = 0xFFF00200 when the sampled MSR[IP] is 1 and 0x00000200 when it is 0.
- R2: On an accepted machine check, SRR0 takes the value of nextPcIn sampled in that cycle.
- R3: On an accepted machine check, SRR1 bits 0–11 are cleared and SRR1 bits 16–31 are copied from MSR bits 16–31.
- R4: SRR1 bits 12, 13, 14 and 15 record the machine check pin, transfer error, data parity error and address parity error strobes. When several strobes arrive in one cycle, every matching bit is set and exactly one entry (a single-cycle redirect) is made.
- R5: On entry, the new MSR keeps IP and ILE, sets LE to ILE, and clears every other bit, ME included.
- R6: Checkstop is entered one cycle after any of these: a cause with MSR[ME]=0, ckstpIn, or protoErrIn. Checkstop has priority over an exception and over a return in the same cycle.
- R7: checkstopOut stays high until reset, and no redirect is issued while it is high.
- R8: In checkstop, SRR0, SRR1 and msrOut do not change, whatever the inputs do.
- R9: A return strobe sets msrOut to msrIn with bits 16–31 replaced from SRR1, and redirects to SRR0 one cycle later. A cause in the same cycle wins over the return.
- R10: A return strobe has no effect while in checkstop.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mcpIn | input | 1 | Machine check pin cause strobe |
| teaIn | input | 1 | Transfer error acknowledge cause strobe |
| dpeIn | input | 1 | Data parity error cause strobe |
| apeIn | input | 1 | Address parity error cause strobe |
| ckstpIn | input | 1 | External checkstop request |
| protoErrIn | input | 1 | Transfer protocol error strobe |
| rfiIn | input | 1 | Return-from-interrupt strobe |
| msrIn | input | 32 | Current machine state register |
| nextPcIn | input | 32 | Address of the next instruction to complete |
| srr0Out | output | 32 | Saved resume address |
| srr1Out | output | 32 | Saved status and cause bits |
| msrOut | output | 32 | MSR computed at entry or return |
| redirectValid | output | 1 | One-cycle fetch redirect strobe |
| redirectAddr | output | 32 | Fetch redirect target |
| checkstopOut | output | 1 | Checkstop state indicator |

## Verification
The bench drives several causes at once and checks that every matching cause bit is set while only a single redirect is made. A design that took one entry per cause, or kept only the highest cause, fails here. A transfer error arriving while ME is clear must end in checkstop rather than a second vector; a design that ignored ME would vector again and overwrite SRR0. Once in checkstop, the bench drives further causes, a return strobe and a changing PC, and checks that nothing captured moves and that no redirect appears. Cases where a checkstop request coincides with a cause, or a return coincides with a cause, expose a wrong priority order.

// File: rtl/mchk_pkg.sv
package mchk_pkg;
  localparam int XLEN     = 32;
  localparam int CAUSE_N  = 4;
  // vector indices (index = XLEN-1 - big-endian bit number)
  localparam int MSR_LE   = XLEN - 1 - 31;
  localparam int MSR_IP   = XLEN - 1 - 25;
  localparam int MSR_ME   = XLEN - 1 - 19;
  localparam int MSR_ILE  = XLEN - 1 - 15;
  localparam int COPY_W   = 16;                 // low half copied into SRR1
  localparam int CAUSE_LSB = XLEN - 1 - 15;     // APE at BE15 .. MCP at BE12
  localparam int ZERO_LSB  = CAUSE_LSB + CAUSE_N;

  typedef struct packed {
    logic takeExc;
    logic doRfi;
    logic enterCk;
  } ctlStrobe_t;

  typedef enum logic [0:0] {ST_RUN, ST_CKSTOP} ckState_t;
endpackage

// File: rtl/mchk_ctl.sv
module mchk_ctl
  import mchk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyCause,
  input  logic       meBit,
  input  logic       ckstpReq,
  input  logic       protoErr,
  input  logic       rfiReq,
  output ctlStrobe_t strobe,
  output logic       checkstopOut
);
  ckState_t stateQ;
  logic running;
  logic hardStop;

  always_comb begin
    running        = (stateQ == ST_RUN);
    hardStop       = ckstpReq | protoErr | (anyCause & ~meBit);
    strobe.enterCk = running & hardStop;
    strobe.takeExc = running & ~hardStop & anyCause;
    strobe.doRfi   = running & ~hardStop & ~anyCause & rfiReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               stateQ <= ST_RUN;
    else if (strobe.enterCk) stateQ <= ST_CKSTOP;
  end

  assign checkstopOut = (stateQ == ST_CKSTOP);

  // R7: checkstop is left only through reset
  p_ck_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    checkstopOut |=> checkstopOut);

  // R6: a cause with ME clear leads to checkstop
  p_me_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (anyCause && !meBit) |=> checkstopOut);
endmodule

// File: rtl/mchk_dp.sv
module mchk_dp
  import mchk_pkg::*;
#(
  parameter logic [XLEN-1:0] HIGH_BASE = 32'hFFF0_0000,
  parameter logic [XLEN-1:0] VEC_OFF   = 32'h0000_0200
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [CAUSE_N-1:0]  causeVec,
  input  logic [XLEN-1:0]     msrIn,
  input  logic [XLEN-1:0]     nextPc,
  output logic [XLEN-1:0]     srr0Q,
  output logic [XLEN-1:0]     srr1Q,
  output logic [XLEN-1:0]     msrQ,
  output logic                redirectValid,
  output logic [XLEN-1:0]     redirectAddr
);
  logic [XLEN-1:0] excSrr1;
  logic [XLEN-1:0] excMsr;
  logic [XLEN-1:0] rfiMsr;
  logic [XLEN-1:0] handlerAddr;

  for (genvar b = 0; b < XLEN; b++) begin : g_bits
    if (b >= CAUSE_LSB && b < ZERO_LSB) begin : g_cause
      assign excSrr1[b] = causeVec[b - CAUSE_LSB];
    end else if (b < COPY_W) begin : g_copy
      assign excSrr1[b] = msrIn[b];
    end else begin : g_zero
      assign excSrr1[b] = 1'b0;
    end

    if (b == MSR_LE) begin : g_le
      assign excMsr[b] = msrIn[MSR_ILE];
    end else if (b == MSR_ILE || b == MSR_IP) begin : g_keep
      assign excMsr[b] = msrIn[b];
    end else begin : g_clr
      assign excMsr[b] = 1'b0;
    end
  end

  assign rfiMsr      = {msrIn[XLEN-1:COPY_W], srr1Q[COPY_W-1:0]};
  assign handlerAddr = (msrIn[MSR_IP] ? HIGH_BASE : '0) | VEC_OFF;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srr0Q         <= '0;
      srr1Q         <= '0;
      msrQ          <= '0;
      redirectValid <= 1'b0;
      redirectAddr  <= '0;
    end else begin
      redirectValid <= strobe.takeExc | strobe.doRfi;
      if (strobe.takeExc) begin
        srr0Q        <= nextPc;
        srr1Q        <= excSrr1;
        msrQ         <= excMsr;
        redirectAddr <= handlerAddr;
      end else if (strobe.doRfi) begin
        msrQ         <= rfiMsr;
        redirectAddr <= srr0Q;
      end
    end
  end

  // R2: resume address captured from the PC of the entry cycle
  p_srr0_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeExc |=> srr0Q == $past(nextPc));

  // R1: handler vector follows IP
  p_vector_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeExc |=> redirectValid &&
      redirectAddr == ($past(msrIn[MSR_IP]) ? 32'hFFF0_0200 : 32'h0000_0200));

  // R3: top twelve bits of SRR1 never set
  p_srr1_hi_r3: assert property (@(posedge clk) disable iff (!rstN)
    srr1Q[XLEN-1:ZERO_LSB] == '0);

  // R5: entry disables further machine checks and sets LE from ILE
  p_entry_msr_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeExc |=> !msrQ[MSR_ME] && msrQ[MSR_LE] == $past(msrIn[MSR_ILE]));

  // R9: return goes to the saved address
  p_rfi_target_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doRfi |=> redirectValid && redirectAddr == $past(srr0Q));
endmodule

// File: rtl/mchk_ctrl.sv
module mchk_ctrl
  import mchk_pkg::*;
#(
  parameter logic [31:0] HIGH_BASE = 32'hFFF0_0000,
  parameter logic [31:0] VEC_OFF   = 32'h0000_0200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mcpIn,
  input  logic        teaIn,
  input  logic        dpeIn,
  input  logic        apeIn,
  input  logic        ckstpIn,
  input  logic        protoErrIn,
  input  logic        rfiIn,
  input  logic [31:0] msrIn,
  input  logic [31:0] nextPcIn,
  output logic [31:0] srr0Out,
  output logic [31:0] srr1Out,
  output logic [31:0] msrOut,
  output logic        redirectValid,
  output logic [31:0] redirectAddr,
  output logic        checkstopOut
);
  ctlStrobe_t          strobe;
  logic [CAUSE_N-1:0]  causeVec;

  assign causeVec = {mcpIn, teaIn, dpeIn, apeIn};

  mchk_ctl i_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .anyCause     (|causeVec),
    .meBit        (msrIn[MSR_ME]),
    .ckstpReq     (ckstpIn),
    .protoErr     (protoErrIn),
    .rfiReq       (rfiIn),
    .strobe       (strobe),
    .checkstopOut (checkstopOut)
  );

  mchk_dp #(.HIGH_BASE(HIGH_BASE), .VEC_OFF(VEC_OFF)) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .causeVec      (causeVec),
    .msrIn         (msrIn),
    .nextPc        (nextPcIn),
    .srr0Q         (srr0Out),
    .srr1Q         (srr1Out),
    .msrQ          (msrOut),
    .redirectValid (redirectValid),
    .redirectAddr  (redirectAddr)
  );

  // R6: external stop or protocol error always ends in checkstop
  p_ck_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ckstpIn || protoErrIn) |=> checkstopOut);

  // R8: captured state frozen once stopped
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    checkstopOut |=> $stable(srr0Out) && $stable(srr1Out) && $stable(msrOut));

  // R10: return ignored in checkstop
  p_rfi_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (checkstopOut && rfiIn) |=> !redirectValid);

  // R7: no redirect while stopped
  p_no_redirect_r7: assert property (@(posedge clk) disable iff (!rstN)
    checkstopOut |-> !redirectValid);
endmodule

// File: tb/test_mchk_ctrl.sv
`timescale 1ns/1ps
module test_mchk_ctrl;
  logic clk = 0;
  logic rstN = 0;
  logic mcpIn = 0, teaIn = 0, dpeIn = 0, apeIn = 0;
  logic ckstpIn = 0, protoErrIn = 0, rfiIn = 0;
  logic [31:0] msrIn = 0, nextPcIn = 0;
  logic [31:0] srr0Out, srr1Out, msrOut, redirectAddr;
  logic redirectValid, checkstopOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit compareOn = 0;

  // reference state
  logic [31:0] mSrr0 = 0, mSrr1 = 0, mMsr = 0, mRa = 0;
  logic mRv = 0, mCk = 0;

  mchk_ctrl i_mchk_ctrl (.*);

  always #2 clk = ~clk;

  function automatic int bx(int n); return 31 - n; endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, updated on each rising edge from the stable inputs
  always @(posedge clk) begin
    int causes;
    logic [31:0] s1, nm;
    causes = mcpIn + teaIn + dpeIn + apeIn;
    if (!rstN) begin
      mSrr0 = 0; mSrr1 = 0; mMsr = 0; mRa = 0; mRv = 0; mCk = 0;
    end else if (mCk) begin
      mRv = 0;
    end else if (ckstpIn || protoErrIn || (causes > 0 && !msrIn[bx(19)])) begin
      mCk = 1; mRv = 0;
    end else if (causes > 0) begin
      s1 = 0;
      for (int n = 16; n < 32; n++) s1[bx(n)] = msrIn[bx(n)];
      s1[bx(12)] = mcpIn; s1[bx(13)] = teaIn;
      s1[bx(14)] = dpeIn; s1[bx(15)] = apeIn;
      nm = 0;
      nm[bx(15)] = msrIn[bx(15)];
      nm[bx(25)] = msrIn[bx(25)];
      nm[bx(31)] = msrIn[bx(15)];
      mSrr0 = nextPcIn; mSrr1 = s1; mMsr = nm;
      mRa = msrIn[bx(25)] ? 32'hFFF0_0200 : 32'h0000_0200;
      mRv = 1;
    end else if (rfiIn) begin
      nm = msrIn;
      for (int n = 16; n < 32; n++) nm[bx(n)] = mSrr1[bx(n)];
      mMsr = nm; mRa = mSrr0; mRv = 1;
    end else begin
      mRv = 0;
    end
  end

  always @(negedge clk) begin
    if (compareOn) begin
      check("R2", srr0Out, mSrr0);
      check("R3", srr1Out, mSrr1);
      check("R5", msrOut, mMsr);
      check("R4", {31'b0, redirectValid}, {31'b0, mRv});
      if (mRv) check("R1", redirectAddr, mRa);
      check("R6", {31'b0, checkstopOut}, {31'b0, mCk});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drive(bit mcp, bit tea, bit dpe, bit ape, bit ck, bit pe, bit rfi);
    @(negedge clk);
    mcpIn = mcp; teaIn = tea; dpeIn = dpe; apeIn = ape;
    ckstpIn = ck; protoErrIn = pe; rfiIn = rfi;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; mcpIn = 0; teaIn = 0; dpeIn = 0; apeIn = 0;
    ckstpIn = 0; protoErrIn = 0; rfiIn = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  // MSR bit helpers (big-endian numbering)
  localparam logic [31:0] ME_M  = 32'h1 << 12;
  localparam logic [31:0] IP_M  = 32'h1 << 6;
  localparam logic [31:0] ILE_M = 32'h1 << 16;

  initial begin
    logic [31:0] f0, f1, f2;
    repeat (3) @(negedge clk);
    // R11: reset values
    check("R11", srr0Out, 0); check("R11", srr1Out, 0); check("R11", msrOut, 0);
    check("R11", {30'b0, redirectValid, checkstopOut}, 0);
    rstN = 1;
    compareOn = 1;
    idle(2);

    // R1 R2: single machine check pin cause, IP=0
    msrIn = ME_M | 32'h0000_A5C3; nextPcIn = 32'h0000_1234;
    drive(1, 0, 0, 0, 0, 0, 0);
    idle(1);
    // R9: return restores state and jumps back
    msrIn = 32'h1357_0000; drive(0, 0, 0, 0, 0, 0, 1);
    idle(2);
    // R1 R5: IP=1, ILE=1, transfer error
    msrIn = ME_M | IP_M | ILE_M | 32'hFFFF_0F0F; nextPcIn = 32'h8000_0040;
    drive(0, 1, 0, 0, 0, 0, 0);
    idle(1);
    // R4: all four causes together, one entry
    msrIn = ME_M | 32'h0000_3C3C; nextPcIn = 32'h0000_2000;
    drive(1, 1, 1, 1, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R4", {31'b0, redirectValid}, 0);
    check("R4", srr1Out & 32'h000F_0000, 32'h000F_0000);
    idle(1);
    // R9: cause beats a return in the same cycle
    msrIn = ME_M; nextPcIn = 32'h0000_3000;
    drive(0, 0, 1, 0, 0, 0, 1);
    idle(1);
    // mixed stimulus with ME held set
    for (int i = 0; i < 300; i++) begin
      msrIn = $urandom | ME_M; nextPcIn = $urandom;
      drive(($urandom % 5) == 0, ($urandom % 7) == 0, ($urandom % 9) == 0,
            ($urandom % 11) == 0, 0, 0, ($urandom % 4) == 0);
    end
    idle(2);

    // R6: transfer error while ME clear (handler has not re-enabled)
    msrIn = 32'h0000_0011; nextPcIn = 32'h0000_4444;
    drive(0, 1, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R6", {31'b0, checkstopOut}, 1);
    f0 = srr0Out; f1 = srr1Out; f2 = msrOut;
    // R8 R10 R7: frozen, return ignored, sticky
    msrIn = ME_M | 32'h0000_FFFF;
    for (int i = 0; i < 20; i++) begin
      nextPcIn = $urandom;
      drive(i[0], i[1], 1, 0, 0, 0, 1);
      @(negedge clk);
      check("R8", srr0Out, f0); check("R8", srr1Out, f1); check("R8", msrOut, f2);
      check("R10", {31'b0, redirectValid}, 0);
      check("R7", {31'b0, checkstopOut}, 1);
    end

    // R6: external checkstop beats a cause in the same cycle
    compareOn = 0; doReset(); compareOn = 1;
    msrIn = ME_M; nextPcIn = 32'h0000_5555;
    drive(1, 0, 0, 0, 1, 0, 0);
    idle(1);
    check("R6", srr0Out, 0);
    idle(3);

    // R6: protocol error alone
    compareOn = 0; doReset(); compareOn = 1;
    drive(0, 0, 0, 0, 0, 1, 0);
    idle(3);
    check("R6", {31'b0, checkstopOut}, 1);

    compareOn = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule